// File: doc/BRIEF.md
# Indirect-Addressing Instruction Cycle Sequencer

This block is the control state machine that steps a 16-bit accumulator minicomputer through each instruction cycle. It holds the program counter and walks four states: fetch, defer, extra-defer and execute. It joins the page bits of the program counter with the 11-bit operand of the current instruction to form the direct address. For an indirect instruction it reads a pointer word from memory. In extended mode it keeps following pointers for as long as each fetched word has bit 15 set. Fixed low locations in every 2K-word page act as index registers. Passing through one of them increments or decrements the pointer and writes the new value back to that location.

An external decoder supplies a summary of the current instruction: an indirect flag, an operate/IOT flag and the 11-bit operand. The execution unit watches a one-cycle execute strobe together with the resolved address. It stops the sequencer with a halt pulse and rewrites the program counter through a load port. Memory is a single synchronous word port: read data returns one cycle after the read request, and a write takes effect at the clock edge. The block also tells the interrupt logic when an interrupt may be taken.

Top module: `indirect_seq`

## Requirements
- R1: After reset the program counter is 0x020, the sequencer is halted (`running_o` low), `state_o` reads fetch (0), and no memory access or execute strobe is issued.
- R2: While halted, the state does not change and no memory read, memory write or execute strobe occurs, whatever the decode inputs are. A `start_i` pulse makes the next cycle a running fetch cycle.
- R3: In fetch, an instruction with the operate/IOT flag set and the indirect flag clear raises `exec_o` in that same cycle, with `state_o` still fetch.
- R4: A direct memory-reference instruction spends one cycle in fetch and one in execute. In the execute cycle `exec_addr_o` equals the program counter's bits above bit 10 joined with the 11-bit operand, and the state after execute is fetch.
- R5: An indirect instruction goes to defer, which reads the word at the direct address. In base mode (`ext_mode_i` low) exactly one level is taken, and execute uses the low address bits of that pointer even if its bit 15 is set.
- R6: In extended mode, a defer or extra-defer pointer word with bit 15 set leads to extra-defer, which reads through that pointer. The chain ends at the first word with bit 15 clear. Each level costs a read cycle and an evaluate cycle.
- R7: When the location read in either defer state has low 11 bits from 0x08 to 0x0F, the pointer is incremented by one, written back to that location in one extra cycle of the same state, and the incremented value is used as the address.
- R8: In extended mode only, locations with low 11 bits from 0x10 to 0x17 decrement the pointer in the same way. In base mode those locations are read without any write-back.
- R9: In extended mode, while the program counter lies in 0x020 to 0x03F, indirection is limited to a single level.
- R10: `int_ok_o` is high exactly when the state is fetch and `byte_pend_i` is low.
- R11: `state_o` encodes fetch as 0, defer as 1, extra-defer as 2 and execute as 3.
- R12: A `halt_i` pulse applied during the execute strobe stops the sequencer. The state still returns to fetch, and nothing further happens until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: begin running |
| halt_i | input | 1 | Pulse: stop running (wins over start) |
| ext_mode_i | input | 1 | 1 = extended mode (multi-level chains, auto-decrement) |
| byte_pend_i | input | 1 | A byte-access modifier is pending |
| ins_indirect_i | input | 1 | Current instruction is indirect |
| ins_opr_i | input | 1 | Current instruction is operate/IOT class |
| ins_operand_i | input | 11 | Operand field of the current instruction |
| pc_wr_i | input | 1 | Load the program counter |
| pc_wdata_i | input | AW | New program counter value |
| pc_o | output | AW | Program counter |
| running_o | output | 1 | Sequencer is running |
| state_o | output | 2 | Cycle state (see R11) |
| int_ok_o | output | 1 | An interrupt may be accepted |
| exec_o | output | 1 | Execute strobe |
| exec_addr_o | output | AW | Resolved operand address |
| mem_addr_o | output | AW | Memory word address |
| mem_re_o | output | 1 | Memory read request |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the request |

## Verification
The hardest situation to reach from the ports is a multi-level extended-mode chain whose levels themselves pass through index locations. There the adjusted pointer, not the stored one, picks the next address, and a write-back cycle separates the read from the state decision. The bench drives every combination of mode, boot-window or normal program counter, operand inside the increment block, inside the decrement block or outside both, and chain depth one to three. It seeds the chain words at index locations in both pages. For each run it computes the expected path, write-backs, cycle count and final address with its own reference walk over a shadow memory.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int WORD_W   = 16;
  localparam int OPND_W   = 11;
  localparam int CHAIN_B  = 15;
  localparam int BOOT_LO  = 16'h0020;
  localparam int BOOT_HI  = 16'h003F;
  localparam int RESET_PC = 16'h0020;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DEFER  = 2'd1,
    ST_XDEFER = 2'd2,
    ST_EXEC   = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_RD = 2'd0,
    PH_EV = 2'd1,
    PH_WB = 2'd2
  } defer_phase_e;

  typedef enum logic [1:0] {
    IX_NONE = 2'd0,
    IX_INC  = 2'd1,
    IX_DEC  = 2'd2
  } index_kind_e;

  // Which index behaviour a location has, from its in-page offset.
  function automatic index_kind_e classify_loc(input logic [OPND_W-1:0] low,
                                               input logic ext);
    index_kind_e k;
    k = IX_NONE;
    if (low >= 11'h008 && low <= 11'h00F) k = IX_INC;
    else if (ext && low >= 11'h010 && low <= 11'h017) k = IX_DEC;
    return k;
  endfunction

  // Pointer value after the index side effect.
  function automatic logic [WORD_W-1:0] adjust_ptr(input logic [WORD_W-1:0] w,
                                                   input index_kind_e k);
    logic [WORD_W-1:0] r;
    case (k)
      IX_INC:  r = w + 16'd1;
      IX_DEC:  r = w - 16'd1;
      default: r = w;
    endcase
    return r;
  endfunction

  // Bootstrap window: single-level indirection only.
  function automatic logic in_boot_window(input logic [WORD_W-1:0] pcw);
    return (pcw >= WORD_W'(BOOT_LO)) && (pcw <= WORD_W'(BOOT_HI));
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         halt_i,
  input  logic         ins_indirect_i,
  input  logic         ins_opr_i,
  input  logic         ext_mode_i,
  input  logic         boot_i,
  input  index_kind_e  kind_i,
  input  logic         chain_now_i,
  input  logic         chain_q_i,
  output seq_state_e   state_o,
  output defer_phase_e phase_o,
  output logic         running_o,
  output logic         rd_o,
  output logic         cap_o,
  output logic         wb_o,
  output logic         exec_o,
  output logic         latch_o
);

  seq_state_e   state_q, state_d;
  defer_phase_e phase_q, phase_d;
  logic         run_q;
  logic         more_now, more_q;

  // Another level follows? The first level obeys mode and boot window.
  always_comb begin
    if (state_q == ST_XDEFER) begin
      more_now = chain_now_i;
      more_q   = chain_q_i;
    end else begin
      more_now = ext_mode_i && !boot_i && chain_now_i;
      more_q   = ext_mode_i && !boot_i && chain_q_i;
    end
  end

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    rd_o    = 1'b0;
    cap_o   = 1'b0;
    wb_o    = 1'b0;
    exec_o  = 1'b0;
    latch_o = 1'b0;
    if (run_q) begin
      case (state_q)
        ST_FETCH: begin
          latch_o = 1'b1;
          phase_d = PH_RD;
          if (ins_indirect_i)  state_d = ST_DEFER;
          else if (ins_opr_i)  exec_o  = 1'b1;
          else                 state_d = ST_EXEC;
        end
        ST_DEFER, ST_XDEFER: begin
          case (phase_q)
            PH_RD: begin
              rd_o    = 1'b1;
              phase_d = PH_EV;
            end
            PH_EV: begin
              cap_o = 1'b1;
              if (kind_i != IX_NONE) begin
                phase_d = PH_WB;
              end else begin
                phase_d = PH_RD;
                state_d = more_now ? ST_XDEFER : ST_EXEC;
              end
            end
            PH_WB: begin
              wb_o    = 1'b1;
              phase_d = PH_RD;
              state_d = more_q ? ST_XDEFER : ST_EXEC;
            end
            default: phase_d = PH_RD;
          endcase
        end
        ST_EXEC: begin
          exec_o  = 1'b1;
          state_d = ST_FETCH;
        end
        default: state_d = ST_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      phase_q <= PH_RD;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      if (halt_i)       run_q <= 1'b0;
      else if (start_i) run_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign phase_o   = phase_q;
  assign running_o = run_q;

endmodule

// File: rtl/seq_addr_unit.sv
module seq_addr_unit
  import seq_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-OPND_W-1:0] page_i,
  input  logic [OPND_W-1:0] operand_i,
  input  logic              ind_i,
  input  logic [AW-1:0]     ptr_i,
  input  seq_state_e        state_i,
  input  logic              latch_i,
  input  logic              rd_i,
  input  logic              ext_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic [AW-1:0]     exec_addr_o,
  output index_kind_e       kind_o
);

  logic [AW-1:0] ea_live, ea_q, acc_q, acc_sel;
  logic          ind_q;

  assign ea_live = {page_i, operand_i};
  assign acc_sel = (state_i == ST_XDEFER) ? ptr_i : ea_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      ind_q <= 1'b0;
      acc_q <= '0;
    end else begin
      if (latch_i) begin
        ea_q  <= ea_live;
        ind_q <= ind_i;
      end
      if (rd_i) acc_q <= acc_sel;
    end
  end

  // Read cycle drives the fresh selection; evaluate and write-back reuse it.
  assign mem_addr_o = rd_i ? acc_sel : acc_q;
  assign kind_o     = classify_loc(acc_q[OPND_W-1:0], ext_i);

  always_comb begin
    if (state_i == ST_FETCH) exec_addr_o = ea_live;
    else if (ind_q)          exec_addr_o = ptr_i;
    else                     exec_addr_o = ea_q;
  end

endmodule

// File: rtl/seq_ptr_unit.sv
module seq_ptr_unit
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  index_kind_e       kind_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] ptr_o,
  output logic              chain_o
);

  logic [WORD_W-1:0] ptr_q;
  logic              chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      chain_q <= 1'b0;
    end else if (cap_i) begin
      ptr_q   <= adjust_ptr(rdata_i, kind_i);
      chain_q <= rdata_i[CHAIN_B];
    end
  end

  assign ptr_o   = ptr_q;
  assign chain_o = chain_q;

endmodule

// File: rtl/indirect_seq.sv
module indirect_seq
  import seq_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic              ext_mode_i,
  input  logic              byte_pend_i,
  input  logic              ins_indirect_i,
  input  logic              ins_opr_i,
  input  logic [10:0]       ins_operand_i,
  input  logic              pc_wr_i,
  input  logic [AW-1:0]     pc_wdata_i,
  output logic [AW-1:0]     pc_o,
  output logic              running_o,
  output logic [1:0]        state_o,
  output logic              int_ok_o,
  output logic              exec_o,
  output logic [AW-1:0]     exec_addr_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [15:0]       mem_wdata_o,
  input  logic [15:0]       mem_rdata_i
);

  localparam int PAGE_W = AW - OPND_W;

  logic [AW-1:0]     pc_q;
  seq_state_e        state;
  defer_phase_e      phase;
  index_kind_e       kind;
  logic [WORD_W-1:0] ptr;
  logic              chain_q;
  logic              boot;

  // Named internal events, for the checker.
  logic ev_read, ev_capture, ev_writeback, ev_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= AW'(RESET_PC);
    else if (pc_wr_i) pc_q <= pc_wdata_i;
  end

  assign boot = in_boot_window(WORD_W'(pc_q));

  seq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .halt_i         (halt_i),
    .ins_indirect_i (ins_indirect_i),
    .ins_opr_i      (ins_opr_i),
    .ext_mode_i     (ext_mode_i),
    .boot_i         (boot),
    .kind_i         (kind),
    .chain_now_i    (mem_rdata_i[CHAIN_B]),
    .chain_q_i      (chain_q),
    .state_o        (state),
    .phase_o        (phase),
    .running_o      (running_o),
    .rd_o           (ev_read),
    .cap_o          (ev_capture),
    .wb_o           (ev_writeback),
    .exec_o         (exec_o),
    .latch_o        (ev_latch)
  );

  seq_addr_unit #(.AW(AW)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .page_i      (pc_q[AW-1:OPND_W]),
    .operand_i   (ins_operand_i),
    .ind_i       (ins_indirect_i),
    .ptr_i       (ptr[AW-1:0]),
    .state_i     (state),
    .latch_i     (ev_latch),
    .rd_i        (ev_read),
    .ext_i       (ext_mode_i),
    .mem_addr_o  (mem_addr_o),
    .exec_addr_o (exec_addr_o),
    .kind_o      (kind)
  );

  seq_ptr_unit u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (ev_capture),
    .kind_i  (kind),
    .rdata_i (mem_rdata_i),
    .ptr_o   (ptr),
    .chain_o (chain_q)
  );

  assign pc_o        = pc_q;
  assign state_o     = state;
  assign int_ok_o    = (state == ST_FETCH) && !byte_pend_i;
  assign mem_re_o    = ev_read;
  assign mem_we_o    = ev_writeback;
  assign mem_wdata_o = ptr;

  if (PAGE_W < 1) begin : g_bad_width
    initial $error("indirect_seq: AW must exceed the operand width");
  end

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running_o,
  input logic [1:0]    state_o,
  input logic          exec_o,
  input logic          int_ok_o,
  input logic          byte_pend_i,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          ext_mode_i
);

  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> (!mem_re_o && !mem_we_o && !exec_o));

  p_halt_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |=> $stable(state_o));

  p_exec_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |-> (state_o == 2'd3 || state_o == 2'd0));

  p_exec_returns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && state_o == 2'd3) |=> (state_o == 2'd0));

  p_wb_in_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (state_o == 2'd1 || state_o == 2'd2));

  p_wb_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !ext_mode_i) |-> (mem_addr_o[10:0] >= 11'h008 && mem_addr_o[10:0] <= 11'h00F));

  p_wb_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(!mem_re_o && running_o));

  p_xdefer_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |-> ext_mode_i);

  p_int_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int_ok_o |-> (state_o == 2'd0 && !byte_pend_i));

endmodule

bind indirect_seq seq_checker #(.AW(AW)) u_seq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .running_o   (running_o),
  .state_o     (state_o),
  .exec_o      (exec_o),
  .int_ok_o    (int_ok_o),
  .byte_pend_i (byte_pend_i),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_addr_o  (mem_addr_o),
  .ext_mode_i  (ext_mode_i)
);

// File: tb/test_indirect_seq.sv
module test_indirect_seq;

  localparam int AW = 12;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, halt_i = 1'b0, ext_mode_i = 1'b0, byte_pend_i = 1'b0;
  logic          ins_indirect_i = 1'b0, ins_opr_i = 1'b0;
  logic [10:0]   ins_operand_i = '0;
  logic          pc_wr_i = 1'b0;
  logic [AW-1:0] pc_wdata_i = '0;
  logic [AW-1:0] pc_o, exec_addr_o, mem_addr_o;
  logic          running_o, int_ok_o, exec_o, mem_re_o, mem_we_o;
  logic [1:0]    state_o;
  logic [15:0]   mem_wdata_o, mem_rdata_i;

  logic [15:0] mem  [MW];
  logic [15:0] rmem [MW];
  logic [AW-1:0] touched [16];
  int ntouch;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  indirect_seq #(.AW(AW)) i_indirect_seq (.*);

  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference walk of the indirect chain over the shadow memory.
  task automatic ref_walk(input bit ext, input logic [AW-1:0] pc, input logic [10:0] op,
                          output logic [AW-1:0] xaddr, output int cyc, output bit more_lvl);
    logic [AW-1:0] a;
    logic [15:0]   w, nw;
    bit first, more, boot;
    int lo;
    a = {pc[AW-1:11], op};
    first = 1; cyc = 1; more_lvl = 0; ntouch = 0;
    boot = (pc >= 12'h020 && pc <= 12'h03F);
    for (int lvl = 0; lvl < 8; lvl++) begin
      w = rmem[a];
      touched[ntouch] = a; ntouch++;
      cyc += 2;
      lo = int'(a[10:0]);
      nw = w;
      if (lo >= 8 && lo <= 15) begin nw = w + 16'd1; rmem[a] = nw; cyc++; end
      else if (ext && lo >= 16 && lo <= 23) begin nw = w - 16'd1; rmem[a] = nw; cyc++; end
      more = first ? (ext && !boot && w[15]) : w[15];
      a = nw[AW-1:0];
      first = 0;
      if (!more) break;
      more_lvl = 1;
    end
    xaddr = a;
    cyc += 1;
  endtask

  task automatic set_pc(input logic [AW-1:0] v);
    @(negedge clk); pc_wr_i = 1'b1; pc_wdata_i = v;
    @(negedge clk); pc_wr_i = 1'b0;
  endtask

  // kind: 0 operate, 1 direct, 2..4 indirect with chain depth kind-1
  task automatic run_case(input bit ext, input logic [AW-1:0] pc, input logic [10:0] op,
                          input int kind, input bit bp);
    logic [AW-1:0] ea, xexp;
    logic [AW-1:0] tgt [3];
    int cyc_exp, cyc, depth;
    bit more_exp, seen_x, done;
    ea = {pc[AW-1:11], op};
    for (int i = 0; i < MW; i++) begin mem[i] = 16'h0; rmem[i] = 16'h0; end
    tgt[0] = 12'h00C; tgt[1] = 12'h815; tgt[2] = 12'h7A0;
    depth = kind - 1;
    if (kind >= 2) begin
      mem[ea] = ((depth > 1) ? 16'h8000 : 16'h0) | 16'(tgt[0]);
      for (int k = 1; k < depth; k++)
        mem[tgt[k-1]] = ((k + 1 < depth) ? 16'h8000 : 16'h0) | 16'(tgt[k]);
      // seed neighbours so adjusted pointers still land on chain words
      mem[tgt[0] + 12'd1] = 16'h8000 | 16'(tgt[1]);
      mem[tgt[0] - 12'd1] = 16'h0123;
      for (int i = 0; i < MW; i++) rmem[i] = mem[i];
    end
    ext_mode_i = ext; byte_pend_i = bp;
    ins_operand_i = op;
    ins_opr_i = (kind == 0);
    ins_indirect_i = (kind >= 2);
    set_pc(pc);
    if (kind == 0)      begin cyc_exp = 1; xexp = ea; more_exp = 0; ntouch = 0; end
    else if (kind == 1) begin cyc_exp = 2; xexp = ea; more_exp = 0; ntouch = 0; end
    else ref_walk(ext, pc, op, xexp, cyc_exp, more_exp);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    cyc = 1; seen_x = 0; done = 0;
    while (!done && cyc < 40) begin
      // R10: interrupt window only in fetch with no byte modifier pending
      chk(int_ok_o == (state_o == 2'd0 && !bp), "R10 int_ok", int_ok_o, (state_o == 2'd0 && !bp));
      if (cyc == 1) chk(state_o == 2'd0, "R11 fetch code", state_o, 0);
      if (cyc == 2 && kind >= 2) chk(state_o == 2'd1, "R11 defer code", state_o, 1);
      if (state_o == 2'd2) seen_x = 1;
      if (exec_o) begin
        done = 1;
        halt_i = 1'b1;
        if (kind == 0) begin
          chk(cyc == 1 && state_o == 2'd0, "R3 operate in fetch", cyc, 1);
        end else begin
          chk(state_o == 2'd3, "R11 exec code", state_o, 3);
          chk(cyc == cyc_exp, (kind == 1) ? "R4 cycles" : "R6 cycles", cyc, cyc_exp);
        end
        chk(exec_addr_o == xexp, (kind <= 1) ? "R4 address" : (ext ? "R6 address" : "R5 address"),
            exec_addr_o, xexp);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!done) chk(0, "watchdog run hung", cyc, cyc_exp);
    @(negedge clk); halt_i = 1'b0;
    chk(state_o == 2'd0 && !running_o, "R12 halted after execute", {running_o, state_o}, 0);
    if (kind >= 2) begin
      chk(seen_x == more_exp, (ext && pc <= 12'h03F && pc >= 12'h020) ? "R9 boot single level" : "R6 extra defer",
          seen_x, more_exp);
      for (int i = 0; i < ntouch; i++)
        chk(mem[touched[i]] == rmem[touched[i]],
            (touched[i][10:0] >= 11'h010 && touched[i][10:0] <= 11'h017) ? "R8 decrement writeback" : "R7 increment writeback",
            mem[touched[i]], rmem[touched[i]]);
    end
    repeat (2) begin
      @(negedge clk);
      chk(!exec_o && !mem_re_o && state_o == 2'd0, "R12 stays stopped", exec_o, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] pcs [3];
    logic [10:0]   ops [4];
    int run;
    pcs[0] = 12'h020; pcs[1] = 12'h100; pcs[2] = 12'h900;
    ops[0] = 11'h005; ops[1] = 11'h00A; ops[2] = 11'h012; ops[3] = 11'h40C;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pc_o == 12'h020, "R1 reset pc", pc_o, 12'h020);
    chk(!running_o, "R1 halted", running_o, 0);
    chk(state_o == 2'd0 && !exec_o && !mem_re_o && !mem_we_o, "R1 idle", state_o, 0);
    rst_n = 1'b1;
    // R2: halted ignores decode inputs
    ins_indirect_i = 1'b1; ins_operand_i = 11'h00A;
    repeat (5) begin
      @(negedge clk);
      chk(state_o == 2'd0 && !mem_re_o && !mem_we_o && !exec_o, "R2 halted no progress", state_o, 0);
    end
    run = 0;
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 3; p++)
        for (int o = 0; o < 4; o++)
          for (int k = 0; k < 5; k++) begin
            run_case(e[0], pcs[p], ops[o], k, run[0]);
            run++;
          end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule